// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter for operating-system time bases. Software programs a 24-bit reload value and sets an enable bit. The counter then counts down from the reload value. When the count reaches zero, the block sets a sticky flag and can raise a one-cycle interrupt-pending request toward the interrupt controller.

Each count step comes from one of two sources, chosen by a control bit. One source is every core clock cycle. The other is an external reference-tick enable, which advances the counter only in cycles where that input is high.

Software reaches four word-offset registers over a plain 32-bit read/write port. Word 0 is control/status, word 1 is reload, word 2 is current value and word 3 is calibration. Reading the control register clears the sticky flag. Writing the current-value register restarts the count. A reload value of zero turns the counter off after one more expiry.

Top module: `systick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers all read 0, and `irq_req` is low.
- R2: The control word has these bits: bit 0 enable, bit 1 tick-interrupt enable, bit 2 clock source (1 = core clock, 0 = reference tick), and bit 16 the sticky count flag. A write changes only bits [2:0]. Bit 16 cannot be written, and all other bits read 0.
- R3: The reload and current-value registers are 24 bits wide, and bits [31:24] always read 0.
- R4: Writing enable from 0 to 1 loads the reload value R into the counter. The counter then expires R+1 ticks after that write, and every R+1 ticks after that.
- R5: With clock source 1, the counter moves every cycle. With clock source 0, it moves only in cycles where `ref_tick` is high, and otherwise holds its value.
- R6: An expiry sets the count flag. `irq_req` pulses high for exactly one cycle after the expiry, and only when the tick-interrupt enable bit is 1.
- R7: A read of the control register returns the flag as it was before the read, then clears the flag. An expiry in the same cycle wins over the clear.
- R8: Any write to the current-value register, whatever its data, reloads the counter from the reload value and clears the count flag.
- R9: The current-value register reads 0 while the enable bit is 0.
- R10: If the reload value is 0 when the counter expires, the enable bit clears by itself and counting stops.
- R11: A control write that keeps enable at 1 but changes the clock-source bit reloads the counter. A control write that changes neither enable nor clock source leaves the count unchanged.
- R12: The calibration register (word 3) reads the constant 10000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_tick | input | 1 | External reference-tick enable, one count step per high cycle when selected |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data is valid in the same cycle |
| addr | input | 2 | Word offset: 0 control, 1 reload, 2 current value, 3 calibration |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when `rd_en` is low |
| irq_req | output | 1 | One-cycle interrupt-pending request |

## Verification
The bench sweeps small reload values in core-clock mode and counts the edges between an enable write and each request. An off-by-one in the zero slot would show up there as a period of R or R+2 instead of R+1. It steps the reference-tick mode one pulse at a time, which catches a counter that runs on the core clock regardless of the source bit. It also hits the side effects: the flag cleared by a control read, the reload on a current-value write, the reload when the clock source is switched, and the reload-zero case, where a counter that stayed on would keep pulsing. A design that fired the request with tick-interrupt disabled, or let bit 16 or bits [31:24] be written, fails the readback checks.

// File: rtl/systick_pkg.sv
package systick_pkg;

  typedef enum logic [1:0] {
    OFF_CTRL    = 2'd0,
    OFF_RELOAD  = 2'd1,
    OFF_CURRENT = 2'd2,
    OFF_CALIB   = 2'd3
  } reg_off_e;

  localparam int BIT_EN      = 0;
  localparam int BIT_TICKINT = 1;
  localparam int BIT_CLKSRC  = 2;
  localparam int BIT_FLAG    = 16;

endpackage

// File: rtl/systick_rst_sync.sv
module systick_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/systick_tick_gen.sv
module systick_tick_gen (
  input  logic en,
  input  logic clksrc,
  input  logic ref_tick,
  output logic tick
);

  // Core clock when clksrc is set, otherwise the external enable.
  always_comb tick = en & (clksrc | ref_tick);

endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_ce;
  logic             at_zero;

  always_comb begin
    at_zero  = (count_q == '0);
    // Expiry is the tick taken in the zero slot; a software load wins.
    expire   = tick & at_zero & ~load;
    count_ce = load | tick;
    if (load || at_zero) count_d = reload;
    else                 count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_ce) count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter int CALIB_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wdata_lo,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic              en,
  output logic              tickint,
  output logic              clksrc,
  output logic              flag,
  output logic [CNT_W-1:0]  reload,
  output logic              load,
  output logic              irq_req,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] CAL_WORD = DATA_W'(CALIB_VALUE);

  logic             ctrl_wr, rel_wr, cur_wr, ctrl_rd;
  logic             en_rise, src_flip, auto_stop;
  logic [2:0]       ctrl_q, ctrl_d;
  logic             ctrl_ce;
  logic             flag_q, flag_d, flag_ce;
  logic [CNT_W-1:0] reload_q;
  logic             irq_q, irq_d;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    ctrl_wr  = wr_en && (addr == OFF_CTRL);
    rel_wr   = wr_en && (addr == OFF_RELOAD);
    cur_wr   = wr_en && (addr == OFF_CURRENT);
    ctrl_rd  = rd_en && (addr == OFF_CTRL);

    en_rise  = ctrl_wr & wdata_lo[BIT_EN] & ~ctrl_q[BIT_EN];
    src_flip = ctrl_wr & wdata_lo[BIT_EN] & ctrl_q[BIT_EN] &
               (wdata_lo[BIT_CLKSRC] != ctrl_q[BIT_CLKSRC]);
    load     = en_rise | src_flip | cur_wr;

    auto_stop = expire & (reload_q == '0);
    ctrl_ce   = ctrl_wr | auto_stop;
    if (ctrl_wr) begin
      ctrl_d = wdata_lo[2:0];
    end else begin
      ctrl_d = ctrl_q;
      ctrl_d[BIT_EN] = 1'b0;
    end

    flag_ce = expire | ctrl_rd | cur_wr;
    flag_d  = expire;

    irq_d   = expire & ctrl_q[BIT_TICKINT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reload_q <= '0;
    else if (rel_wr) reload_q <= wdata_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      OFF_CTRL: begin
        rd_word[BIT_EN]      = ctrl_q[BIT_EN];
        rd_word[BIT_TICKINT] = ctrl_q[BIT_TICKINT];
        rd_word[BIT_CLKSRC]  = ctrl_q[BIT_CLKSRC];
        rd_word[BIT_FLAG]    = flag_q;
      end
      OFF_RELOAD:  rd_word[CNT_W-1:0] = reload_q;
      OFF_CURRENT: if (ctrl_q[BIT_EN]) rd_word[CNT_W-1:0] = count;
      OFF_CALIB:   rd_word = CAL_WORD;
      default:     rd_word = '0;
    endcase
    rdata = rd_en ? rd_word : '0;
  end

  assign en      = ctrl_q[BIT_EN];
  assign tickint = ctrl_q[BIT_TICKINT];
  assign clksrc  = ctrl_q[BIT_CLKSRC];
  assign flag    = flag_q;
  assign reload  = reload_q;
  assign irq_req = irq_q;

endmodule

// File: rtl/systick_timer.sv
module systick_timer #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter int CALIB_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_req
);

  logic             rst_sync_n;
  logic             ctrl_en, ctrl_tickint, ctrl_clksrc, cnt_flag;
  logic             tick, load_req, expire;
  logic [CNT_W-1:0] reload_q, count_q;
  logic             wdata_unused;

  assign wdata_unused = ^wdata[DATA_W-1:CNT_W];

  systick_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  systick_tick_gen u_tick (
    .en       (ctrl_en),
    .clksrc   (ctrl_clksrc),
    .ref_tick (ref_tick),
    .tick     (tick)
  );

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .load   (load_req),
    .reload (reload_q),
    .count  (count_q),
    .expire (expire)
  );

  systick_regs #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .CALIB_VALUE (CALIB_VALUE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata_lo (wdata[CNT_W-1:0]),
    .count    (count_q),
    .expire   (expire),
    .en       (ctrl_en),
    .tickint  (ctrl_tickint),
    .clksrc   (ctrl_clksrc),
    .flag     (cnt_flag),
    .reload   (reload_q),
    .load     (load_req),
    .irq_req  (irq_req),
    .rdata    (rdata)
  );

endmodule

// File: rtl/systick_timer_chk.sv
module systick_timer_chk #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter int CALIB_VALUE = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_req,
  input logic              en,
  input logic              clksrc,
  input logic              flag,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  count
);

  // R6: a request is always accompanied by the sticky flag
  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag);

  // R3: upper byte of reload readback is zero
  assert_reload_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |-> (rdata[DATA_W-1:CNT_W] == '0));

  // R9: disabled counter reads zero
  assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && !en) |-> (rdata == '0));

  // R12: calibration constant
  assert_calib_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> (rdata == DATA_W'(CALIB_VALUE)));

  // R7: control read with no counting leaves the flag clear
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !en) |=> !flag);

  // R8: current-value write reloads and clears the flag
  assert_cur_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (count == $past(reload) && !flag));

  // R5: reference mode holds without a reference tick
  assert_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clksrc && !ref_tick && !wr_en) |=> $stable(count));

endmodule

bind systick_timer systick_timer_chk #(
  .DATA_W      (DATA_W),
  .CNT_W       (CNT_W),
  .CALIB_VALUE (CALIB_VALUE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ref_tick (ref_tick),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .irq_req  (irq_req),
  .en       (ctrl_en),
  .clksrc   (ctrl_clksrc),
  .flag     (cnt_flag),
  .reload   (reload_q),
  .count    (count_q)
);

// File: tb/systick_timer_test.sv
module systick_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_REL = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;

  systick_timer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    #1;
    v = rdata;
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic ref_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      step(1);
      ref_tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    bit seen;
    rst_n = 1'b0; ref_tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = 2'd0; wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state
    check("R1 irq", {31'b0, irq_req}, 32'd0);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    rd(A_REL, v);  check("R1 reload", v, 32'd0);
    rd(A_CUR, v);  check("R1 current", v, 32'd0);
    // R12 calibration
    rd(A_CAL, v);  check("R12 calib", v, 32'd10000);

    // R2 only bits [2:0] writable, bit 16 not writable
    wr(A_CTRL, 32'hFFFF_FFF8); rd(A_CTRL, v); check("R2 upper bits", v, 32'd0);
    wr(A_CTRL, 32'h0001_0006); rd(A_CTRL, v); check("R2 flag not writable", v, 32'h6);
    wr(A_CTRL, 32'd0);

    // R3 24-bit reload and current value
    wr(A_REL, 32'hFFFF_FFFF); rd(A_REL, v); check("R3 reload width", v, 32'h00FF_FFFF);
    wr(A_CTRL, 32'h1);  // enable, reference mode, frozen
    rd(A_CUR, v); check("R3 current width", v, 32'h00FF_FFFF);
    wr(A_CTRL, 32'h0);

    // R4/R5/R6 core-clock period sweep with interrupt enabled
    for (int r = 1; r <= 6; r++) begin
      wr(A_CTRL, 32'h0);
      wr(A_REL, r);
      wr(A_CTRL, 32'h7);
      n = 0;
      do begin step(1); n++; end while (irq_req !== 1'b1 && n < 64);
      check($sformatf("R4 first expiry r=%0d", r), n, r + 1);
      step(1); n = 1;
      check($sformatf("R6 pulse width r=%0d", r), {31'b0, irq_req}, 32'd0);
      while (irq_req !== 1'b1 && n < 64) begin step(1); n++; end
      check($sformatf("R5 core period r=%0d", r), n, r + 1);
      // R6 tick interrupt disabled: no request, but the flag still sets
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v);
      wr(A_CTRL, 32'h5);
      seen = 0;
      for (int i = 0; i < 3 * (r + 1); i++) begin
        step(1);
        if (irq_req === 1'b1) seen = 1;
      end
      check($sformatf("R6 no irq when disabled r=%0d", r), {31'b0, seen}, 32'd0);
      wr(A_CTRL, 32'h4);  // stop, keep clock source
      rd(A_CTRL, v);
      check($sformatf("R6 flag set r=%0d", r), v, 32'h0001_0004);
    end
    wr(A_CTRL, 32'h0);

    // R5 reference-tick mode
    wr(A_REL, 32'd9);
    wr(A_CTRL, 32'h1);
    step(5);
    rd(A_CUR, v); check("R5 hold without ref", v, 32'd9);
    ref_pulse(1);
    rd(A_CUR, v); check("R5 one ref step", v, 32'd8);

    // R6/R7 expiry in reference mode, flag clear on read
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd2);
    wr(A_CTRL, 32'h1);
    ref_pulse(2);
    rd(A_CUR, v); check("R4 reaches zero", v, 32'd0);
    ref_pulse(1);
    check("R6 no irq tickint off", {31'b0, irq_req}, 32'd0);
    rd(A_CTRL, v); check("R7 read shows flag", v, 32'h0001_0001);
    rd(A_CTRL, v); check("R7 read cleared flag", v, 32'h0000_0001);
    rd(A_CUR, v);  check("R4 wrap reloads", v, 32'd2);

    // R8 current-value write restarts and clears the flag
    ref_pulse(3);
    wr(A_CUR, 32'hDEAD_BEEF);
    rd(A_CTRL, v); check("R8 flag cleared", v, 32'h0000_0001);
    rd(A_CUR, v);  check("R8 reloaded", v, 32'd2);

    // R9 disabled reads zero; re-enable reloads (R4)
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd30);
    rd(A_CUR, v); check("R9 disabled reads 0", v, 32'd0);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, v); check("R4 enable loads", v, 32'd30);

    // R11 clock-source switch reloads; same-source write does not
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd20);
    wr(A_CTRL, 32'h5);
    step(5);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, v); check("R11 source switch reload", v, 32'd20);
    ref_pulse(3);
    wr(A_CTRL, 32'h3);
    rd(A_CUR, v); check("R11 tickint write keeps count", v, 32'd17);

    // R10 zero reload stops after one expiry
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v);
    wr(A_REL, 32'd0);
    wr(A_CTRL, 32'h7);
    check("R10 pre-expiry irq low", {31'b0, irq_req}, 32'd0);
    step(1);
    check("R10 expiry irq", {31'b0, irq_req}, 32'd1);
    rd(A_CTRL, v); check("R10 auto disable", v, 32'h0001_0006);
    rd(A_CUR, v);  check("R10 R9 stopped reads 0", v, 32'd0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (irq_req === 1'b1) seen = 1;
    end
    check("R10 no further requests", {31'b0, seen}, 32'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule